// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block is the interrupt front end of one 32-pin GPIO bank. Each clock cycle it looks at the already synchronized pin levels. For every pin it decides whether an event has happened, using three per-pin configuration bits: a trigger kind (level or edge), a sense (high/rising or low/falling) and a both-edges flag. Every event is recorded in a sticky status register. Software clears that register by writing ones to it.

A per-pin mask sits between the status bits and the single interrupt output. The mask cannot be written directly. Software changes it through two write-only strobe registers: one clears mask bits and the other sets them. Detection and status capture keep running while a pin is masked. An event that arrives while a pin is masked therefore shows up on the interrupt line as soon as the pin is unmasked. Software that wants to avoid this should clear the status bit before unmasking the pin.

The register port is a simple single-cycle write strobe with a combinational read-back. Register words are selected by a 3-bit word address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every mask bit is 1, every status bit is 0, the trigger-kind, sense and both-edges registers read 0, and irq_o is 0.
- R2: A pin whose trigger-kind bit is 0 is in level mode. With sense 1 it sets its status bit on every cycle the pin is high; with sense 0 it sets it on every cycle the pin is low. A status clear issued while the active level holds leaves the bit set.
- R3: A pin whose trigger-kind bit is 1 is in edge mode. The current sample is compared with the previous one. With both-edges 0, sense 1 reacts only to a 0-to-1 change and sense 0 reacts only to a 1-to-0 change. The event is captured once, and a steady level afterwards does not set the bit again.
- R4: In edge mode with both-edges 1, both changes set the status bit whatever the sense bit holds. In level mode the both-edges bit has no effect.
- R5: Writing the status word clears exactly the bits written as 1. Bits written as 0 keep their value, and with no event and no clear a status bit holds.
- R6: Writing 1s to the unmask strobe clears those mask bits, and writing 1s to the mask-set strobe sets them. Zero bits in either write, and writes to the read-only mask word, leave the mask unchanged.
- R7: Event capture continues while a pin is masked. Unmasking a pin whose status bit is 1 raises irq_o in the cycle after the unmask write.
- R8: irq_o is 1 exactly when some pin has status 1 and mask 0. Masking the last such pin, or clearing its status, drops irq_o.
- R9: If a new event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R10: Word addresses: 0 trigger kind (read/write), 1 sense (read/write), 2 both-edges (read/write), 3 status (read, write-1-to-clear), 4 mask (read-only), 5 unmask strobe (write-only, reads 0), 6 mask-set strobe (write-only, reads 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data, one bit per pin |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pin_i | input | 32 | Synchronized pin levels |
| irq_o | output | 1 | Combined interrupt, any unmasked pending pin |

## Verification
The bench aims at the cases where a wrong design looks plausible. The first is a clear written while a level is still active: a design that let the clear win would drop a live level request. The second is a clear that coincides with a fresh edge, where a clear-wins design loses an event without trace. It also checks that an edge pin does not re-arm while its level holds; a design that compared against a stale sample would fire on every cycle. The both-edges bit must be ignored in level mode, and mis-decoding it turns a level pin into an edge pin. Finally, an event captured while masked must appear on irq_o at unmask time. A design that gated capture with the mask would stay silent there, and one whose strobe writes disturbed unrelated mask bits would raise or drop the interrupt for the wrong pin.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_TRIG     = 3'd0,
    REG_SENSE    = 3'd1,
    REG_BOTH     = 3'd2,
    REG_STATUS   = 3'd3,
    REG_MASK     = 3'd4,
    REG_UNMASK   = 3'd5,
    REG_MASK_SET = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] trig_edge_o,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_edge_o <= '0;
      sense_o     <= '0;
      both_o      <= '0;
      mask_o      <= '1;
    end else if (wr_en_i) begin
      case (sel_i)
        REG_TRIG:     trig_edge_o <= wdata_i;
        REG_SENSE:    sense_o     <= wdata_i;
        REG_BOTH:     both_o      <= wdata_i;
        REG_UNMASK:   mask_o      <= mask_o & ~wdata_i;
        REG_MASK_SET: mask_o      <= mask_o | wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] trig_edge_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  output logic [NUM_PINS-1:0] evt_o
);
  logic [NUM_PINS-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, edg_hit, lvl_hit;
    assign rise    = pin_i[i] & ~pin_q[i];
    assign fall    = ~pin_i[i] & pin_q[i];
    assign edg_hit = both_i[i] ? (rise | fall) : (sense_i[i] ? rise : fall);
    assign lvl_hit = sense_i[i] ? pin_i[i] : ~pin_i[i];
    assign evt_o[i] = trig_edge_i[i] ? edg_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);
  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | evt_i;
  end

  assign irq_o = |(status_o & ~mask_i);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic                  irq_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] edge_mode_q, sense_q, both_q, mask_q, status_q;
  logic [NUM_PINS-1:0] evt, clr;

  assign sel = reg_sel_e'(addr_i);
  assign clr = (wr_en_i && sel == REG_STATUS) ? wdata_i : '0;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .trig_edge_o (edge_mode_q),
    .sense_o     (sense_q),
    .both_o      (both_q),
    .mask_o      (mask_q)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .trig_edge_i (edge_mode_q),
    .sense_i     (sense_q),
    .both_i      (both_q),
    .evt_o       (evt)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .clr_i    (clr),
    .mask_i   (mask_q),
    .status_o (status_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (sel)
      REG_TRIG:   rdata_o = edge_mode_q;
      REG_SENSE:  rdata_o = sense_q;
      REG_BOTH:   rdata_o = both_q;
      REG_STATUS: rdata_o = status_q;
      REG_MASK:   rdata_o = mask_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [NUM_PINS-1:0]   pin_i,
  input logic                  irq_o,
  input logic [NUM_PINS-1:0]   status,
  input logic [NUM_PINS-1:0]   mask,
  input logic [NUM_PINS-1:0]   trig_edge,
  input logic [NUM_PINS-1:0]   sense
);
  logic [NUM_PINS-1:0] lvl_active;
  assign lvl_active = ~trig_edge & ~(sense ^ pin_i);

  assert_status_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_STATUS) |=> ((status & $past(status)) == $past(status)));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == REG_UNMASK || addr_i == REG_MASK_SET)) |=> $stable(mask));

  assert_level_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & $past(lvl_active)) == $past(lvl_active)));

  assert_irq_has_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0));

  assert_all_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |-> !irq_o);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .pin_i     (pin_i),
  .irq_o     (irq_o),
  .status    (status_q),
  .mask      (mask_q),
  .trig_edge (edge_mode_q),
  .sense     (sense_q)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam logic [2:0] A_TRIG = 3'd0, A_SENSE = 3'd1, A_BOTH = 3'd2, A_STAT = 3'd3,
                         A_MASK = 3'd4, A_UNMASK = 3'd5, A_MSET = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '1;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1 chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic restore();
    pins = '1;
    wr(A_TRIG, '0); wr(A_SENSE, '0); wr(A_BOTH, '0);
    wr(A_MSET, '1); wr(A_STAT, '1);
    rd_chk("restore status", A_STAT, 32'h0);
  endtask

  task automatic t_reset();
    irq_chk("R1 irq", 1'b0);
    rd_chk("R1 trig", A_TRIG, 32'h0);
    rd_chk("R1 sense", A_SENSE, 32'h0);
    rd_chk("R1 both", A_BOTH, 32'h0);
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 mask", A_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic t_regmap();
    wr(A_TRIG, 32'hA5A5_A5A5);
    wr(A_SENSE, 32'h0F0F_0F0F);
    wr(A_BOTH, 32'h1234_5678);
    wr(A_MASK, 32'h0);
    rd_chk("R10 trig", A_TRIG, 32'hA5A5_A5A5);
    rd_chk("R10 sense", A_SENSE, 32'h0F0F_0F0F);
    rd_chk("R10 both", A_BOTH, 32'h1234_5678);
    rd_chk("R6 mask read-only", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R10 unmask reads 0", A_UNMASK, 32'h0);
    rd_chk("R10 mask-set reads 0", A_MSET, 32'h0);
    restore();
  endtask

  task automatic t_mask_ctrl();
    wr(A_UNMASK, 32'h0000_00F0);
    rd_chk("R6 unmask", A_MASK, 32'hFFFF_FF0F);
    wr(A_UNMASK, 32'h0);
    rd_chk("R6 unmask zero", A_MASK, 32'hFFFF_FF0F);
    wr(A_MSET, 32'h0000_0010);
    rd_chk("R6 mask-set", A_MASK, 32'hFFFF_FF1F);
    wr(A_MSET, 32'h0);
    rd_chk("R6 mask-set zero", A_MASK, 32'hFFFF_FF1F);
    wr(A_MSET, '1);
    rd_chk("R6 all masked", A_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    wr(A_SENSE, 32'h1);
    rd_chk("R2 level high sets", A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    rd_chk("R2 clear while active", A_STAT, 32'h1);
    pins[0] = 1'b0;
    rd_chk("R2 sticky after level ends", A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    rd_chk("R2 cleared after level ends", A_STAT, 32'h0);
    pins[1] = 1'b0;
    rd_chk("R2 level low sets", A_STAT, 32'h2);
    restore();
  endtask

  task automatic t_edge();
    wr(A_TRIG, 32'h0000_000C);
    wr(A_SENSE, 32'h0000_0004);
    wr(A_STAT, '1);
    rd_chk("R3 idle", A_STAT, 32'h0);
    pins[2] = 1'b0;
    rd_chk("R3 fall ignored by rising pin", A_STAT, 32'h0);
    pins[2] = 1'b1;
    rd_chk("R3 rise", A_STAT, 32'h4);
    wr(A_STAT, 32'h4);
    rd_chk("R3 no re-arm on steady level", A_STAT, 32'h0);
    pins[3] = 1'b0;
    rd_chk("R3 fall", A_STAT, 32'h8);
    pins[3] = 1'b1;
    wr(A_STAT, 32'h8);
    rd_chk("R3 rise ignored by falling pin", A_STAT, 32'h0);
    pins[2] = 1'b0;
    rd_chk("R9 prep", A_STAT, 32'h0);
    @(negedge clk);
    pins[2] = 1'b1;
    wr_en = 1'b1; addr = A_STAT; wdata = 32'h4;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R9 event beats clear", A_STAT, 32'h4);
    restore();
  endtask

  task automatic t_both();
    wr(A_TRIG, 32'h10);
    wr(A_SENSE, 32'h10);
    wr(A_BOTH, 32'h30);
    wr(A_STAT, '1);
    rd_chk("R4 idle", A_STAT, 32'h0);
    pins[4] = 1'b0;
    rd_chk("R4 fall with sense high", A_STAT, 32'h10);
    wr(A_STAT, 32'h10);
    rd_chk("R4 cleared", A_STAT, 32'h0);
    pins[4] = 1'b1;
    rd_chk("R4 rise", A_STAT, 32'h10);
    wr(A_STAT, 32'h10);
    pins[5] = 1'b0;
    rd_chk("R4 level pin with both set", A_STAT, 32'h20);
    wr(A_STAT, 32'h20);
    rd_chk("R4 both ignored in level mode", A_STAT, 32'h20);
    restore();
  endtask

  task automatic t_w1c();
    pins[1] = 1'b0; pins[6] = 1'b0;
    rd_chk("R5 captured", A_STAT, 32'h42);
    pins = '1;
    rd_chk("R5 sticky", A_STAT, 32'h42);
    wr(A_STAT, 32'h0);
    rd_chk("R5 zero write", A_STAT, 32'h42);
    wr(A_STAT, 32'h2);
    rd_chk("R5 selective clear", A_STAT, 32'h40);
    wr(A_STAT, 32'h40);
    rd_chk("R5 last clear", A_STAT, 32'h0);
  endtask

  task automatic t_masked();
    pins[6] = 1'b0;
    rd_chk("R7 captured while masked", A_STAT, 32'h40);
    irq_chk("R7 masked quiet", 1'b0);
    pins = '1;
    rd_chk("R7 still held", A_STAT, 32'h40);
    wr(A_UNMASK, 32'h80);
    irq_chk("R8 unmask idle pin", 1'b0);
    wr(A_UNMASK, 32'h40);
    irq_chk("R7 irq on unmask", 1'b1);
    wr(A_MSET, 32'h40);
    irq_chk("R8 remask drops irq", 1'b0);
    wr(A_UNMASK, 32'h40);
    irq_chk("R8 unmask again", 1'b1);
    wr(A_STAT, 32'h40);
    irq_chk("R8 clear drops irq", 1'b0);
    pins[7] = 1'b0;
    @(negedge clk);
    irq_chk("R8 other pin", 1'b1);
    restore();
    irq_chk("R8 quiet after restore", 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_mask_ctrl();
    t_level();
    t_edge();
    t_both();
    t_w1c();
    t_masked();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule